// File: doc/BRIEF.md
# Command Phase Busy Tracker

This block sequences a byte-wide command interface through its command, result and seek phases, and drives the handshake and busy bits of the main status register. The host writes command bytes and reads result bytes one at a time. Before each transfer it checks the ready bit `rqm` and the direction bit `dio`. The tracker decides from the first byte how many parameter bytes to expect and how many result bytes to return. It holds `cmd_busy` high while a command is in progress. It keeps one busy bit per drive for each drive that is moving its head.

Seek-type commands have no result phase. For these, `cmd_busy` is released as soon as the last command byte is accepted, and the seek continues in the background on its drive. This lets the host start a seek on another drive while the first one is still moving. A drive's busy bit is cleared by a pulse on that drive's seek-complete input. Opcode execution is a placeholder. A known command with results returns result byte k holding the value k. An unknown opcode goes straight to a one-byte result of 0x80.

Top module: `cmdtrk_top`

## Requirements
- R1: After a synchronous reset, `cmd_busy` = 0, `drv_busy` = 0, `rqm` = 1 and `dio` = 0.
- R2: A write is accepted when `wr_stb`, `rqm` = 1 and `dio` = 0 are all present at a clock edge. `cmd_busy` reads 1 in the cycle after the first command byte is accepted.
- R3: After each accepted write or read, `rqm` is 0 for exactly one cycle and is then 1 again.
- R4: `dio` is 0 throughout the command phase and 1 throughout the result phase. While `dio` = 1, `rd_data` shows the result byte that the next read will consume.
- R5: For a command with a result phase, `cmd_busy` stays 1 until the last result byte has been read. In the cycle after that read, `cmd_busy` = 0 and `dio` = 0.
- R6: Seek (opcode 0x0F, three bytes) and recalibrate (opcode 0x07, two bytes) have no result phase. In the cycle after their last byte, `cmd_busy` = 0 and `dio` = 0. The target drive is bits [1:0] of the second byte.
- R7: At the end of a seek or recalibrate, `drv_busy` bit x of the target drive is set. It stays set across later commands, so several drives can be busy at once.
- R8: A one-cycle pulse on `seek_done[x]` clears `drv_busy[x]` in the next cycle, whatever the command phase. If the same edge also ends a new seek on drive x, the bit stays set.
- R9: The opcode is decoded from bits [4:0] of the first byte:
  - 0x04: 2 bytes, 1 result.
  - 0x08: 1 byte, 2 results.
  - 0x06: 9 bytes, 7 results.
  - Result byte k (counting from 0) of a known command is k.
- R10: Any other opcode enters the result phase right after its single byte and returns one result byte, 0x80.
- R11: A strobe is ignored when `rqm` = 0 or when it points the wrong way (a write while `dio` = 1, or a read while `dio` = 0). An ignored strobe changes neither the phase nor the byte count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_stb | input | 1 | Host presents a command byte |
| wr_data | input | 8 | Command byte from the host |
| rd_stb | input | 1 | Host consumes a result byte |
| seek_done | input | 4 | Per-drive seek-complete pulses |
| rd_data | output | 8 | Current result byte |
| rqm | output | 1 | Ready for a byte transfer |
| dio | output | 1 | Direction: 0 host-to-block, 1 block-to-host |
| cmd_busy | output | 1 | Command in progress |
| drv_busy | output | 4 | Per-drive seek in progress |

## Verification
The bench builds the block with its default parameters: an 8-bit data path and four drives. With four drives, the bench can run two seeks on different drives at the same time. It can also reach the case where a seek-complete pulse and the end of a new seek hit the same drive on the same edge. The nine-byte command takes the byte counter to its widest value. Every drive-select code from 1 to 3 appears in the drive selects that the bench sends.

// File: rtl/cmdtrk_pkg.sv
`timescale 1ns/1ps
package cmdtrk_pkg;
  localparam int CNT_W = 4;

  typedef struct packed {
    logic [CNT_W-1:0] n_cmd;
    logic [CNT_W-1:0] n_res;
    logic             seek;
    logic             bad;
  } op_info_t;

  localparam logic [4:0] OP_RECAL = 5'h07;
  localparam logic [4:0] OP_SEEK  = 5'h0F;
  localparam logic [4:0] OP_DSTAT = 5'h04;
  localparam logic [4:0] OP_ISTAT = 5'h08;
  localparam logic [4:0] OP_XFER  = 5'h06;

  function automatic op_info_t op_lookup(input logic [4:0] code);
    op_info_t r;
    r = '0;
    unique case (code)
      OP_RECAL: begin r.n_cmd = 4'd2; r.n_res = 4'd0; r.seek = 1'b1; end
      OP_SEEK:  begin r.n_cmd = 4'd3; r.n_res = 4'd0; r.seek = 1'b1; end
      OP_DSTAT: begin r.n_cmd = 4'd2; r.n_res = 4'd1; end
      OP_ISTAT: begin r.n_cmd = 4'd1; r.n_res = 4'd2; end
      OP_XFER:  begin r.n_cmd = 4'd9; r.n_res = 4'd7; end
      default:  begin r.n_cmd = 4'd1; r.n_res = 4'd1; r.bad = 1'b1; end
    endcase
    return r;
  endfunction
endpackage

// File: rtl/cmdtrk_decode.sv
`timescale 1ns/1ps
module cmdtrk_decode
  import cmdtrk_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic [DW-1:0] opcode,
  output op_info_t      info
);
  logic unused_hi;
  assign unused_hi = ^opcode[DW-1:5];
  assign info = op_lookup(opcode[4:0]);

  always_comb begin
    assert_len_nonzero_R9: assert (info.n_cmd != '0);
  end
endmodule

// File: rtl/cmdtrk_phase.sv
`timescale 1ns/1ps
module cmdtrk_phase
  import cmdtrk_pkg::*;
#(
  parameter int DW   = 8,
  parameter int NDRV = 4,
  localparam int SELW = (NDRV > 1) ? $clog2(NDRV) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_stb,
  input  logic [SELW-1:0] wr_sel,
  input  logic            rd_stb,
  input  op_info_t        first_info,
  output logic            rqm,
  output logic            dio,
  output logic            busy,
  output logic [DW-1:0]   rd_data,
  output logic            seek_go,
  output logic [SELW-1:0] seek_drv
);
  localparam logic [DW-1:0] BAD_RES = DW'(1) << (DW - 1);

  logic [CNT_W-1:0] cnt_q;
  op_info_t         op_q;
  op_info_t         op_now;
  logic [SELW-1:0]  sel_q;
  logic             wr_ok, rd_ok, first_byte, last_cmd, last_res;
  logic [CNT_W-1:0] cnt_nx;

  function automatic logic [DW-1:0] res_byte(input logic bad, input logic [CNT_W-1:0] k);
    return bad ? BAD_RES : DW'(k);
  endfunction

  assign wr_ok      = wr_stb & rqm & ~dio;
  assign rd_ok      = rd_stb & rqm & dio;
  assign first_byte = (cnt_q == '0);
  assign op_now     = first_byte ? first_info : op_q;
  assign cnt_nx     = cnt_q + CNT_W'(1);
  assign last_cmd   = wr_ok && (cnt_nx == op_now.n_cmd);
  assign last_res   = rd_ok && (cnt_nx == op_q.n_res);
  assign seek_go    = last_cmd && op_now.seek;
  assign seek_drv   = (cnt_q == CNT_W'(1)) ? wr_sel : sel_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rqm     <= 1'b1;
      dio     <= 1'b0;
      busy    <= 1'b0;
      cnt_q   <= '0;
      op_q    <= '0;
      sel_q   <= '0;
      rd_data <= '0;
    end else begin
      rqm <= !(wr_ok || rd_ok);
      if (wr_ok) begin
        if (first_byte) begin
          op_q <= first_info;
          busy <= 1'b1;
        end
        if (cnt_q == CNT_W'(1)) sel_q <= wr_sel;
        if (last_cmd) begin
          cnt_q <= '0;
          if (op_now.n_res != '0) begin
            dio     <= 1'b1;
            rd_data <= res_byte(op_now.bad, '0);
          end else begin
            busy <= 1'b0;
          end
        end else begin
          cnt_q <= cnt_nx;
        end
      end else if (rd_ok) begin
        if (last_res) begin
          cnt_q <= '0;
          dio   <= 1'b0;
          busy  <= 1'b0;
        end else begin
          cnt_q   <= cnt_nx;
          rd_data <= res_byte(op_q.bad, cnt_nx);
        end
      end
    end
  end

  assert_rqm_drop_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_ok || rd_ok) |=> !rqm);
  assert_rqm_back_R3: assert property (@(posedge clk) disable iff (rst)
    !rqm |=> rqm);
  assert_dio_busy_R4: assert property (@(posedge clk) disable iff (rst)
    dio |-> busy);
  assert_busy_set_R2: assert property (@(posedge clk) disable iff (rst)
    (wr_ok && !seek_go) |=> busy);
  assert_seek_end_R6: assert property (@(posedge clk) disable iff (rst)
    seek_go |=> (!busy && !dio));
  assert_res_end_R5: assert property (@(posedge clk) disable iff (rst)
    last_res |=> (!busy && !dio));
  assert_wrong_dir_R11: assert property (@(posedge clk) disable iff (rst)
    (dio && !rd_stb) |=> dio);
endmodule

// File: rtl/cmdtrk_drives.sv
`timescale 1ns/1ps
module cmdtrk_drives #(
  parameter int NDRV = 4,
  localparam int SELW = (NDRV > 1) ? $clog2(NDRV) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            seek_go,
  input  logic [SELW-1:0] seek_drv,
  input  logic [NDRV-1:0] seek_done,
  output logic [NDRV-1:0] drv_busy
);
  for (genvar i = 0; i < NDRV; i++) begin : g_drv
    logic start;
    assign start = seek_go && (seek_drv == SELW'(i));

    always_ff @(posedge clk) begin
      if (rst)               drv_busy[i] <= 1'b0;
      else if (start)        drv_busy[i] <= 1'b1;
      else if (seek_done[i]) drv_busy[i] <= 1'b0;
    end

    assert_drv_set_R7: assert property (@(posedge clk) disable iff (rst)
      start |=> drv_busy[i]);
    assert_drv_clear_R8: assert property (@(posedge clk) disable iff (rst)
      (seek_done[i] && !start) |=> !drv_busy[i]);
    assert_drv_hold_R7: assert property (@(posedge clk) disable iff (rst)
      (drv_busy[i] && !seek_done[i]) |=> drv_busy[i]);
  end
endmodule

// File: rtl/cmdtrk_top.sv
`timescale 1ns/1ps
module cmdtrk_top
  import cmdtrk_pkg::*;
#(
  parameter int DW   = 8,
  parameter int NDRV = 4,
  localparam int SELW = (NDRV > 1) ? $clog2(NDRV) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_stb,
  input  logic [DW-1:0]   wr_data,
  input  logic            rd_stb,
  input  logic [NDRV-1:0] seek_done,
  output logic [DW-1:0]   rd_data,
  output logic            rqm,
  output logic            dio,
  output logic            cmd_busy,
  output logic [NDRV-1:0] drv_busy
);
  op_info_t        first_info;
  logic            seek_go;
  logic [SELW-1:0] seek_drv;

  cmdtrk_decode #(.DW(DW)) u_dec (
    .opcode (wr_data),
    .info   (first_info)
  );

  cmdtrk_phase #(.DW(DW), .NDRV(NDRV)) u_phase (
    .clk        (clk),
    .rst        (rst),
    .wr_stb     (wr_stb),
    .wr_sel     (wr_data[SELW-1:0]),
    .rd_stb     (rd_stb),
    .first_info (first_info),
    .rqm        (rqm),
    .dio        (dio),
    .busy       (cmd_busy),
    .rd_data    (rd_data),
    .seek_go    (seek_go),
    .seek_drv   (seek_drv)
  );

  cmdtrk_drives #(.NDRV(NDRV)) u_drv (
    .clk       (clk),
    .rst       (rst),
    .seek_go   (seek_go),
    .seek_drv  (seek_drv),
    .seek_done (seek_done),
    .drv_busy  (drv_busy)
  );
endmodule

// File: tb/cmdtrk_top_test.sv
`timescale 1ns/1ps
module cmdtrk_top_test;
  localparam int DW = 8, NDRV = 4;

  logic clk = 1'b0, rst = 1'b1, wr_stb = 1'b0, rd_stb = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic [NDRV-1:0] seek_done = '0;
  logic [DW-1:0] rd_data;
  logic rqm, dio, cmd_busy;
  logic [NDRV-1:0] drv_busy;
  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  cmdtrk_top #(.DW(DW), .NDRV(NDRV)) uut (
    .clk(clk), .rst(rst), .wr_stb(wr_stb), .wr_data(wr_data), .rd_stb(rd_stb),
    .seek_done(seek_done), .rd_data(rd_data), .rqm(rqm), .dio(dio),
    .cmd_busy(cmd_busy), .drv_busy(drv_busy)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic gap();
    @(negedge clk);
  endtask

  task automatic put(input logic [7:0] b);
    wr_data = b; wr_stb = 1'b1;
    @(negedge clk);
    wr_stb = 1'b0;
  endtask

  task automatic get(output logic [7:0] b);
    b = rd_data; rd_stb = 1'b1;
    @(negedge clk);
    rd_stb = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 cmd_busy", cmd_busy, 0);
    chk("R1 drv_busy", drv_busy, 0);
    chk("R1 rqm", rqm, 1);
    chk("R1 dio", dio, 0);
  endtask

  task automatic t_drive_status();
    logic [7:0] b;
    put(8'h04);
    chk("R2 busy after first byte", cmd_busy, 1);
    chk("R3 rqm drop on write", rqm, 0);
    chk("R4 dio in command phase", dio, 0);
    gap();
    chk("R3 rqm back", rqm, 1);
    put(8'h01);
    chk("R4 dio in result phase", dio, 1);
    gap();
    chk("R9 result 0", rd_data, 0);
    get(b);
    chk("R3 rqm drop on read", rqm, 0);
    chk("R5 busy after last result", cmd_busy, 0);
    chk("R5 dio after last result", dio, 0);
    gap();
  endtask

  task automatic t_sense();
    logic [7:0] b;
    put(8'h08);
    chk("R9 one-byte cmd to result", dio, 1);
    gap();
    get(b); chk("R9 sense result 0", b, 0);
    gap();
    chk("R5 busy between results", cmd_busy, 1);
    get(b); chk("R9 sense result 1", b, 1);
    chk("R5 busy after sense", cmd_busy, 0);
    gap();
  endtask

  task automatic t_long();
    logic [7:0] b;
    int bad_dio = 0, bad_res = 0;
    put(8'h06); gap();
    for (int i = 1; i < 8; i++) begin
      put(8'(i)); gap();
      if (dio !== 1'b0) bad_dio++;
    end
    chk("R4 dio low through 9-byte cmd", bad_dio, 0);
    put(8'h08);
    chk("R9 result phase after 9th byte", dio, 1);
    gap();
    for (int k = 0; k < 7; k++) begin
      get(b); gap();
      if (b != 8'(k)) bad_res++;
    end
    chk("R9 seven result values", bad_res, 0);
    chk("R5 busy after 7 results", cmd_busy, 0);
  endtask

  task automatic t_seek();
    put(8'h0F); gap();
    put(8'h02); gap();
    chk("R6 busy during seek params", cmd_busy, 1);
    put(8'h25);
    chk("R6 busy clears after seek", cmd_busy, 0);
    chk("R6 no result phase", dio, 0);
    chk("R7 drive 2 busy", drv_busy, 4'b0100);
    gap();
    put(8'h07); gap();
    put(8'h01);
    chk("R6 recal busy clears", cmd_busy, 0);
    chk("R7 overlapped drives", drv_busy, 4'b0110);
    gap();
  endtask

  task automatic t_done();
    seek_done = 4'b0100;
    gap();
    seek_done = '0;
    chk("R8 drive 2 cleared", drv_busy, 4'b0010);
    put(8'h0F); gap();
    put(8'h03); gap();
    wr_data = 8'h10; wr_stb = 1'b1; seek_done = 4'b1000;
    gap();
    wr_stb = 1'b0; seek_done = '0;
    chk("R8 new seek wins over done", drv_busy, 4'b1010);
    gap();
    seek_done = 4'b1010;
    gap();
    seek_done = '0;
    chk("R8 both cleared", drv_busy, 4'b0000);
  endtask

  task automatic t_unknown();
    logic [7:0] b;
    put(8'h1F);
    chk("R10 unknown to result", dio, 1);
    chk("R10 busy set", cmd_busy, 1);
    gap();
    chk("R10 invalid code", rd_data, 8'h80);
    get(b);
    chk("R10 one result only", cmd_busy, 0);
    gap();
  endtask

  task automatic t_ignore();
    logic [7:0] b;
    rd_stb = 1'b1; gap(); rd_stb = 1'b0;
    chk("R11 read in cmd phase ignored rqm", rqm, 1);
    chk("R11 read in cmd phase ignored busy", cmd_busy, 0);
    put(8'h04);
    put(8'h55);
    chk("R11 write while rqm low ignored", dio, 0);
    chk("R11 still busy", cmd_busy, 1);
    put(8'h00);
    chk("R11 real byte accepted", dio, 1);
    gap();
    put(8'h99);
    chk("R11 write in result phase ignored dio", dio, 1);
    chk("R11 write in result phase ignored rqm", rqm, 1);
    chk("R11 result unchanged", rd_data, 0);
    get(b);
    chk("R11 single result consumed", cmd_busy, 0);
    gap();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    gap();
    t_reset();
    t_drive_status();
    t_sense();
    t_long();
    t_seek();
    t_done();
    t_unknown();
    t_ignore();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(200000 * 5);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule